// File: doc/BRIEF.md
# Quadrature NCO Mixer with Phase Dither

This block shifts a channel down to baseband. A numerically controlled oscillator turns a 32-bit phase accumulator into cosine and sine words, and the input samples are multiplied by those words. The accumulator moves forward by the frequency word once for each accepted input sample, not on every core clock. Because the frequency word is unsigned modulo 2^32, a word above half of full scale tunes to a negative frequency. The tuning step is the sample rate divided by 2^32.

Three input modes share the one oscillator. In single real mode only channel A is mixed. In dual real mode channels A and B are both mixed with the same oscillator words, so the two channels get identical phase shifts. In complex mode the two inputs form one I/Q pair and a full complex product is taken. An optional phase dither adds a pseudo-random offset below the truncation point before the phase is cut to the lookup width. This spreads the spurs that phase truncation would otherwise create.

Each result leaves a fixed three-stage pipeline with its own valid strobe.

Top module: `nco_mixer`

## Requirements
- R1: While reset is asserted and just after it is released, `valid_o` is low and all four product outputs are 0. The accumulator restarts at phase 0 and the dither register restarts at the seed value 0xACE1.
- R2: The first strobe after reset uses phase 0. Each strobe then adds `freq_i`, modulo 2^32, to the phase used by the next strobe. Cycles without a strobe do not advance the phase. A word above 2^31 steps the phase backwards, for example 0xFFF00000 steps it by -1 lookup entry.
- R3: The lookup phase p is the top 12 bits of the (possibly dithered) phase. The oscillator words are cos = round(32767·cos(2π(p+0.5)/4096)) and sin = round(32767·sin(2π(p+0.5)/4096)), both signed 16-bit.
- R4: In mode 0 (single real), the channel A outputs are AI = S(a·cos) and AQ = S(−a·sin), and both channel B outputs are 0. Mode 3 behaves the same as mode 0.
- R5: In mode 1 (dual real), channel A is formed as in R4, and channel B is BI = S(b·cos) and BQ = S(−b·sin), using the same cos and sin words as channel A.
- R6: In mode 2 (complex), AI = S(a·cos + b·sin) and AQ = S(b·cos − a·sin), and both channel B outputs are 0.
- R7: The scaling S(x) is floor((x + 2^14) / 2^15), which is round half up. It then saturates to the signed 16-bit range −32768..32767.
- R8: With `dither_en_i` high, the 16-bit dither register value shifted left by 4 is added to the accumulator before truncation. The dither register is a Fibonacci LFSR: its feedback is the XOR of bits 15, 13, 12 and 10, it shifts left with the feedback entering bit 0, and it advances on every strobe whether dither is enabled or not.
- R9: A strobe sampled at a clock edge produces its result and `valid_o` high after the third rising edge counting that one. `valid_o` is high only for results, and the outputs hold their last value while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | An input sample is present this cycle |
| mode_i | input | 2 | 0 single real, 1 dual real, 2 complex, 3 as 0 |
| freq_i | input | 32 | Unsigned tuning word |
| dither_en_i | input | 1 | Enables phase dither |
| a_i | input | 16 | Channel A real sample or I sample (signed) |
| b_i | input | 16 | Channel B real sample or Q sample (signed) |
| valid_o | output | 1 | A result is present on the outputs |
| ai_o | output | 16 | Channel A in-phase product |
| aq_o | output | 16 | Channel A quadrature product |
| bi_o | output | 16 | Channel B in-phase product |
| bq_o | output | 16 | Channel B quadrature product |

## Verification
Two functions can fall in the same cycle. One is a result leaving the pipeline for an earlier sample. The other is a new strobe advancing both the phase accumulator and the dither register. The bench provokes this with back-to-back strobes and random gaps of zero to two idle cycles, while the mode, the tuning word and the dither enable change from sample to sample.

Each result is judged against a bench model of the accumulator and the LFSR. The model steps only on strobes, and the result must appear in exactly the predicted cycle. Directed cases also drive negative tuning words, a dither carry across the truncation point, and complex products that saturate in both directions.

// File: rtl/nco_pkg.sv
package nco_pkg;
   typedef enum logic [1:0] {
      MIX_REAL1 = 2'd0,
      MIX_REAL2 = 2'd1,
      MIX_CPLX  = 2'd2,
      MIX_RSVD  = 2'd3
   } mix_mode_e;
endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
   parameter int PHASE_W = 32,
   parameter int LUT_AW  = 12,
   parameter int LFSR_W  = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe_i,
   input  logic [PHASE_W-1:0] freq_i,
   input  logic               dither_en_i,
   output logic [LUT_AW-1:0]  lut_phase_o
);
   localparam int FRAC_W = PHASE_W - LUT_AW;
   localparam int DSH    = FRAC_W - LFSR_W;

   if (LUT_AW < 3) begin : g_bad_aw
      $error("nco_phase: LUT_AW must be at least 3");
   end
   if (LFSR_W > FRAC_W) begin : g_bad_lfsr
      $error("nco_phase: LFSR_W must fit below the truncation point");
   end
   if (LFSR_SEED == '0) begin : g_bad_seed
      $error("nco_phase: LFSR_SEED must be nonzero");
   end

   logic [PHASE_W-1:0] acc_q;
   logic [LFSR_W-1:0]  lfsr_q;
   logic [PHASE_W-1:0] dith;
   logic [PHASE_W-1:0] sum;
   logic               fb;

   assign fb   = ^(lfsr_q & LFSR_TAPS);
   assign dith = dither_en_i ? (PHASE_W'(lfsr_q) << DSH) : '0;
   assign sum  = acc_q + dith;
   assign lut_phase_o = LUT_AW'(sum >> FRAC_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         lfsr_q <= LFSR_SEED;
      end else if (strobe_i) begin
         acc_q  <= acc_q + freq_i;
         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      end
   end

   // R2: the phase moves only on strobes, and by exactly the tuning word
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> $stable(acc_q));
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> (acc_q == $past(acc_q + freq_i)));
   // R8: the dither register never locks up in the all-zero state
   p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
   parameter int LUT_AW = 12,
   parameter int AMP_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic [LUT_AW-1:0]       phase_i,
   output logic signed [AMP_W-1:0] cos_o,
   output logic signed [AMP_W-1:0] sin_o
);
   localparam int  QAW   = LUT_AW - 2;
   localparam int  QN    = 1 << QAW;
   localparam int  FULL  = 1 << LUT_AW;
   localparam real AMAX  = real'((1 << (AMP_W-1)) - 1);
   localparam real TWOPI = 6.283185307179586;

   logic signed [AMP_W-1:0] rom [QN];

   initial begin
      for (int k = 0; k < QN; k++)
         rom[k] = AMP_W'($rtoi(AMAX * $sin(TWOPI * (real'(k) + 0.5) / real'(FULL)) + 0.5));
   end

   function automatic logic signed [AMP_W-1:0] fold(input logic [LUT_AW-1:0] ph);
      logic [1:0]              quad;
      logic [QAW-1:0]          idx;
      logic signed [AMP_W-1:0] mag;
      quad = ph[LUT_AW-1 -: 2];
      idx  = ph[QAW-1:0];
      mag  = quad[0] ? rom[~idx] : rom[idx];
      return quad[1] ? -mag : mag;
   endfunction

   logic [LUT_AW-1:0] cos_ph;
   assign cos_ph = phase_i + LUT_AW'(QN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cos_o <= '0;
         sin_o <= '0;
      end else if (en_i) begin
         cos_o <= fold(cos_ph);
         sin_o <= fold(phase_i);
      end
   end

   // R3: a folded word never exceeds the symmetric amplitude
   p_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_o != -(2**(AMP_W-1))) && (cos_o != -(2**(AMP_W-1))));
endmodule

// File: rtl/nco_cmul.sv
module nco_cmul #(
   parameter int DATA_W = 16,
   parameter int AMP_W  = 16,
   parameter int OUT_W  = 16
) (
   input  logic signed [DATA_W-1:0] xi_i,
   input  logic signed [DATA_W-1:0] xq_i,
   input  logic signed [AMP_W-1:0]  cos_i,
   input  logic signed [AMP_W-1:0]  sin_i,
   output logic signed [OUT_W-1:0]  yi_o,
   output logic signed [OUT_W-1:0]  yq_o
);
   localparam int PW = DATA_W + AMP_W;
   localparam int SW = PW + 1;
   localparam int RW = SW - (AMP_W - 1);
   localparam logic signed [SW-1:0] HALF = SW'(1) << (AMP_W - 2);
   localparam logic signed [RW-1:0] MAXV = RW'((1 << (OUT_W-1)) - 1);
   localparam logic signed [RW-1:0] MINV = ~MAXV;

   if (OUT_W > RW) begin : g_bad_out
      $error("nco_cmul: OUT_W wider than the scaled product");
   end

   function automatic logic signed [OUT_W-1:0] scale(input logic signed [SW-1:0] s);
      logic signed [SW-1:0] r;
      logic signed [RW-1:0] q;
      r = s + HALF;
      q = RW'(r >>> (AMP_W - 1));
      if (q > MAXV)      return OUT_W'(MAXV);
      else if (q < MINV) return OUT_W'(MINV);
      else               return OUT_W'(q);
   endfunction

   logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
   logic signed [SW-1:0] s_i, s_q;

   assign p_ic = xi_i * cos_i;
   assign p_qs = xq_i * sin_i;
   assign p_qc = xq_i * cos_i;
   assign p_is = xi_i * sin_i;
   assign s_i  = SW'(p_ic) + SW'(p_qs);
   assign s_q  = SW'(p_qc) - SW'(p_is);
   assign yi_o = scale(s_i);
   assign yq_o = scale(s_q);
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
   parameter int PHASE_W = 32,
   parameter int LUT_AW  = 12,
   parameter int LFSR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int AMP_W   = 16,
   parameter int OUT_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     strobe_i,
   input  logic [1:0]               mode_i,
   input  logic [PHASE_W-1:0]       freq_i,
   input  logic                     dither_en_i,
   input  logic signed [DATA_W-1:0] a_i,
   input  logic signed [DATA_W-1:0] b_i,
   output logic                     valid_o,
   output logic signed [OUT_W-1:0]  ai_o,
   output logic signed [OUT_W-1:0]  aq_o,
   output logic signed [OUT_W-1:0]  bi_o,
   output logic signed [OUT_W-1:0]  bq_o
);
   import nco_pkg::*;

   localparam int NCH = 2;

   if (DATA_W < 2 || AMP_W < 3) begin : g_bad_w
      $error("nco_mixer: data or amplitude width too small");
   end

   logic [LUT_AW-1:0] lut_phase;

   nco_phase #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LFSR_W(LFSR_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .freq_i(freq_i),
      .dither_en_i(dither_en_i), .lut_phase_o(lut_phase));

   // stage 1: capture the sample and its truncated phase
   logic                     s1_v;
   logic [LUT_AW-1:0]        s1_ph;
   logic signed [DATA_W-1:0] s1_a, s1_b;
   mix_mode_e                s1_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_ph <= '0; s1_a <= '0; s1_b <= '0; s1_mode <= MIX_REAL1;
      end else begin
         s1_v <= strobe_i;
         if (strobe_i) begin
            s1_ph   <= lut_phase;
            s1_a    <= a_i;
            s1_b    <= b_i;
            s1_mode <= mix_mode_e'(mode_i);
         end
      end
   end

   // stage 2: oscillator words arrive alongside the delayed sample
   logic signed [AMP_W-1:0]  cosw, sinw;
   logic                     s2_v;
   logic signed [DATA_W-1:0] s2_a, s2_b;
   mix_mode_e                s2_mode;

   nco_sincos #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sincos (
      .clk(clk), .rst_n(rst_n), .en_i(s1_v), .phase_i(s1_ph),
      .cos_o(cosw), .sin_o(sinw));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v <= 1'b0; s2_a <= '0; s2_b <= '0; s2_mode <= MIX_REAL1;
      end else begin
         s2_v <= s1_v;
         if (s1_v) begin
            s2_a    <= s1_a;
            s2_b    <= s1_b;
            s2_mode <= s1_mode;
         end
      end
   end

   // channel operand steering; both channels share cosw/sinw
   logic signed [DATA_W-1:0] xi [NCH];
   logic signed [DATA_W-1:0] xq [NCH];
   logic signed [OUT_W-1:0]  yi [NCH];
   logic signed [OUT_W-1:0]  yq [NCH];

   always_comb begin
      xi[0] = s2_a;
      xq[0] = (s2_mode == MIX_CPLX)  ? s2_b : '0;
      xi[1] = (s2_mode == MIX_REAL2) ? s2_b : '0;
      xq[1] = '0;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      nco_cmul #(.DATA_W(DATA_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_cmul (
         .xi_i(xi[c]), .xq_i(xq[c]), .cos_i(cosw), .sin_i(sinw),
         .yi_o(yi[c]), .yq_o(yq[c]));
   end

   // stage 3: registered results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0; ai_o <= '0; aq_o <= '0; bi_o <= '0; bq_o <= '0;
      end else begin
         valid_o <= s2_v;
         if (s2_v) begin
            ai_o <= yi[0];
            aq_o <= yq[0];
            bi_o <= yi[1];
            bq_o <= yq[1];
         end
      end
   end

   // R9: fixed three-edge latency, in both directions
   p_lat_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |-> ##3 valid_o);
   p_lat_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |-> ##3 !valid_o);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ##1 (!valid_o -> ($stable(ai_o) && $stable(bq_o))));
   // R4/R6: channel B stays silent outside dual real mode
   p_b_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && mode_i != 2'd1) |-> ##3 (bi_o == '0 && bq_o == '0));
endmodule

// File: tb/nco_mixer_test.sv
module nco_mixer_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, strobe, dith;
   logic [1:0]  mode;
   logic [31:0] freq;
   logic signed [15:0] a, b;
   logic        valid;
   logic signed [15:0] ai, aq, bi, bq;

   nco_mixer uut (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .mode_i(mode), .freq_i(freq),
      .dither_en_i(dith), .a_i(a), .b_i(b), .valid_o(valid),
      .ai_o(ai), .aq_o(aq), .bi_o(bi), .bq_o(bq));

   int checks = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // bench model state
   logic [31:0] acc_m;
   logic [15:0] lfsr_m;
   int    e_ai [2048], e_aq [2048], e_bi [2048], e_bq [2048], e_cyc [2048];
   string e_tag [2048];
   int    wr = 0, rd = 0;
   bit    mon_on = 0;

   function automatic int lutv(int p, bit is_cos);
      real ang, r;
      ang = 6.283185307179586 * (real'(p) + 0.5) / 4096.0;
      r = 32767.0 * (is_cos ? $cos(ang) : $sin(ang));
      return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
   endfunction

   function automatic int scl(longint s);
      longint r;
      r = (s + 64'sd16384) >>> 15;
      if (r > 32767) return 32767;
      if (r < -32768) return -32768;
      return int'(r);
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] m, input logic [31:0] f, input bit d,
                       input int xa, input int xb, input string tag);
      logic [31:0] ph;
      int p, c, s;
      @(posedge clk); #1;
      strobe = 1'b1; mode = m; freq = f; dith = d; a = 16'(xa); b = 16'(xb);
      ph = acc_m + (d ? ({16'h0, lfsr_m} << 4) : 32'h0);
      p  = int'(ph >> 20);
      c  = lutv(p, 1'b1);
      s  = lutv(p, 1'b0);
      case (m)
         2'd1: begin
            e_ai[wr] = scl(longint'(xa) * c); e_aq[wr] = scl(-(longint'(xa) * s));
            e_bi[wr] = scl(longint'(xb) * c); e_bq[wr] = scl(-(longint'(xb) * s));
         end
         2'd2: begin
            e_ai[wr] = scl(longint'(xa) * c + longint'(xb) * s);
            e_aq[wr] = scl(longint'(xb) * c - longint'(xa) * s);
            e_bi[wr] = 0; e_bq[wr] = 0;
         end
         default: begin
            e_ai[wr] = scl(longint'(xa) * c); e_aq[wr] = scl(-(longint'(xa) * s));
            e_bi[wr] = 0; e_bq[wr] = 0;
         end
      endcase
      e_cyc[wr] = cyc + 3;
      e_tag[wr] = tag;
      wr++;
      acc_m  = acc_m + f;
      lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         strobe = 1'b0;
         a = 16'($urandom); b = 16'($urandom); freq = $urandom;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      strobe = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      acc_m = 32'h0; lfsr_m = 16'hACE1;
      rst_n = 1'b1;
   endtask

   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (valid) begin
            if (rd >= wr || e_cyc[rd] != cyc) begin
               checks++; fails++;
               $display("FAIL R9 valid_o early or spurious actual=1 expected=0 at cycle %0d", cyc);
            end else begin
               chk(e_tag[rd], "ai_o", int'(ai), e_ai[rd]);
               chk(e_tag[rd], "aq_o", int'(aq), e_aq[rd]);
               chk(e_tag[rd], "bi_o", int'(bi), e_bi[rd]);
               chk(e_tag[rd], "bq_o", int'(bq), e_bq[rd]);
               rd++;
            end
         end else if (rd < wr && e_cyc[rd] == cyc) begin
            checks++; fails++;
            $display("FAIL R9 valid_o missing actual=0 expected=1 at cycle %0d", cyc);
            rd++;
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      mode = 2'd0; freq = '0; dith = 1'b0; a = '0; b = '0;
      do_reset();
      // R1: idle state after reset
      @(negedge clk);
      chk("R1", "valid_o", int'(valid), 0);
      chk("R1", "ai_o", int'(ai), 0);
      chk("R1", "bq_o", int'(bq), 0);
      mon_on = 1;

      // R3/R1: first phase is 0, quadrant walk with a quarter-turn step
      send(2'd0, 32'h4000_0000, 1'b0, 32767, 0, "R3");
      send(2'd0, 32'h4000_0000, 1'b0, -32768, 0, "R3");
      send(2'd0, 32'h4000_0000, 1'b0, 32767, 0, "R3");
      send(2'd3, 32'h4000_0000, 1'b0, 12345, 999, "R4");
      idle(1);
      // R2: negative tuning word steps backwards, gaps do not advance
      send(2'd1, 32'hFFF0_0000, 1'b0, 20000, -20000, "R2");
      idle(2);
      send(2'd1, 32'hFFF0_0000, 1'b0, 20000, -20000, "R2");
      send(2'd1, 32'h8000_0000, 1'b0, -1, 1, "R2");
      send(2'd1, 32'h0000_0001, 1'b0, 30000, 7, "R5");
      idle(6);

      // R7: saturation in both directions in complex mode
      do_reset();
      send(2'd2, 32'h2000_0000, 1'b0, -32768, -32768, "R6");
      send(2'd2, 32'h2000_0000, 1'b0, -32768, -32768, "R7");
      send(2'd2, 32'h2000_0000, 1'b0, 100, -100, "R6");
      send(2'd2, 32'h2000_0000, 1'b0, -32767, 32767, "R7");
      idle(6);

      // R8: dither pushes the phase across the truncation boundary
      do_reset();
      send(2'd0, 32'h000F_F000, 1'b1, 30000, 0, "R8");
      for (int i = 0; i < 12; i++)
         send(2'd1, 32'h0000_0000, 1'b1, 30000, -30000, "R8");
      send(2'd0, 32'h0000_0000, 1'b0, 30000, 0, "R8");
      idle(6);

      // random mix of modes, words, dither and gaps
      for (int i = 0; i < 400; i++) begin
         logic [1:0] m;
         bit d;
         string t;
         m = 2'($urandom);
         d = 1'($urandom);
         t = d ? "R8" : (m == 2'd1) ? "R5" : (m == 2'd2) ? "R6" : "R4";
         send(m, $urandom, d, int'(16'sh0 + $signed(16'($urandom))),
              int'(16'sh0 + $signed(16'($urandom))), t);
         idle(int'($urandom_range(0, 2)));
      end
      idle(8);
      chk("R9", "results drained", rd, wr);
      summary();
   end
endmodule